// File: doc/BRIEF.md
# Quadrature Edge Direction Decoder

This block watches two encoder lines and emits one-cycle up and down strobes for a downstream counter. Each line is first brought into the local clock domain by a flop chain and then passed through a stability filter. A change reaches the decoder only after it has been seen on a fixed number of consecutive samples. The decoder compares each filtered level with the level it held one cycle earlier. From that it finds which line moved and in which direction.

A 2-bit edge-select input chooses which transitions count. Code 0 counts rising transitions, code 1 counts falling transitions, and codes 2 and 3 count both. In single-line mode only line A matters, and every selected transition on it is an up step. In quadrature mode both lines count. The direction comes from a table keyed on the line that moved, the kind of transition, and the level of the other line. Selecting one kind of transition gives half resolution, and selecting both gives four steps per encoder period. In quadrature mode, a sample in which both filtered lines change together cannot be decoded. It raises an error flag that stays set until reset.

The block holds no count value.

Top module: `quad_edge_decoder`

## Requirements
- R1: While reset is asserted, and after it is released with both lines held low, `inc_o`, `dec_o` and `err_o` are 0.
- R2: In single-line mode with `edge_sel`=0, a rising transition on line A gives exactly one `inc_o` pulse. A falling transition on A gives none.
- R3: In single-line mode, `edge_sel`=1 makes only falling transitions of A count, and `edge_sel`=2 or 3 makes both kinds count. Each counted transition gives one `inc_o` pulse.
- R4: In single-line mode, line B has no effect. `dec_o` stays 0, and `err_o` never rises, even when A and B change in the same sample.
- R5: In quadrature mode with `edge_sel`=0, a rise of A gives dec when B is 1 and inc when B is 0. A rise of B gives inc when A is 1 and dec when A is 0. Falling transitions give nothing.
- R6: In quadrature mode with `edge_sel`=1, a fall of A gives inc when B is 1 and dec when B is 0. A fall of B gives dec when A is 1 and inc when A is 0. Rising transitions give nothing.
- R7: In quadrature mode with `edge_sel`=2 or 3, the rules of R5 and R6 both apply. A full forward encoder period gives four inc pulses, and a full reverse period gives four dec pulses.
- R8: A line change held for fewer than `FILT_LEN` clock cycles is discarded. A change held for exactly `FILT_LEN` cycles is accepted.
- R9: In quadrature mode, when both filtered lines change in the same sample, no strobe is issued and `err_o` goes to 1. It then stays 1 until reset.
- R10: `inc_o` and `dec_o` are never 1 in the same cycle, and each counted transition gives a pulse exactly one cycle wide.
- R11: Let cycle n be the clock edge that first samples a line change. The strobe is 1 during the cycle that follows clock edge n+`FILT_LEN`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| quad_mode | input | 1 | 1 = quadrature decoding, 0 = single-line up counting on A |
| edge_sel | input | 2 | 0 rising, 1 falling, 2 or 3 both |
| in_a | input | 1 | Encoder line A, asynchronous |
| in_b | input | 1 | Encoder line B, asynchronous |
| inc_o | output | 1 | One-cycle up strobe |
| dec_o | output | 1 | One-cycle down strobe |
| err_o | output | 1 | Sticky flag for an undecodable simultaneous change |

## Verification
The bench steps the lines through forward and reverse Gray sequences under every edge code. A swapped entry in the direction table would show up as an inc where a dec belongs, and a wrong edge enable would produce an extra or a missing pulse. Pulses one cycle shorter than the filter window, and exactly as long as it, probe the acceptance boundary, which an off-by-one filter counter would move. Simultaneous changes are driven in both modes. A decoder that counted them would strobe, and one that also flagged them in single-line mode would raise the error flag. A final reset shows that the flag clears.

// File: rtl/qed_pkg.sv
package qed_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE     = 2'd0,
    EDGE_FALL     = 2'd1,
    EDGE_BOTH     = 2'd2,
    EDGE_BOTH_ALT = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic up;
    logic down;
    logic bad;
  } step_t;

  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/qed_rst_sync.sv
module qed_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/qed_in_sync.sv
module qed_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qed_glitch_filter.sv
module qed_glitch_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  output logic lvl_o
);
  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             cnt_en, lvl_en;

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    cnt_en = 1'b0;
    lvl_en = 1'b0;
    if (smp_i == lvl_q) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q == CNT_LAST) begin
      lvl_en = 1'b1;
      lvl_d  = smp_i;
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/qed_dir_decode.sv
module qed_dir_decode
  import qed_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic                 quad_mode_i,
  input  logic [1:0]           edge_sel_i,
  output logic                 inc_o,
  output logic                 dec_o,
  output logic                 err_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rise, fall, moved;
  logic                 rise_en, fall_en;
  logic                 take_a, take_b;
  edge_sel_e            sel;
  step_t                step;
  logic                 inc_q, dec_q, err_q;
  logic                 err_d;

  assign sel     = edge_sel_e'(edge_sel_i);
  assign rise    = lvl_i & ~prev_q;
  assign fall    = ~lvl_i & prev_q;
  assign moved   = lvl_i ^ prev_q;
  assign rise_en = (sel != EDGE_FALL);
  assign fall_en = (sel != EDGE_RISE);
  assign take_a  = (rise[0] & rise_en) | (fall[0] & fall_en);
  assign take_b  = (rise[1] & rise_en) | (fall[1] & fall_en);

  always_comb begin
    step = '0;
    if (!quad_mode_i) begin
      step.up = take_a;
    end else if (moved == 2'b11) begin
      step.bad = 1'b1;
    end else if (moved[0]) begin
      // A moved: rising with B low counts up, falling with B high counts up
      step.up   = take_a & (rise[0] ? ~lvl_i[1] : lvl_i[1]);
      step.down = take_a & (rise[0] ? lvl_i[1] : ~lvl_i[1]);
    end else if (moved[1]) begin
      // B moved: rising with A high counts up, falling with A low counts up
      step.up   = take_b & (rise[1] ? lvl_i[0] : ~lvl_i[0]);
      step.down = take_b & (rise[1] ? ~lvl_i[0] : lvl_i[0]);
    end
  end

  assign err_d = err_q | step.bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      inc_q  <= 1'b0;
      dec_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      inc_q  <= step.up;
      dec_q  <= step.down;
      err_q  <= err_d;
    end
  end

  assign inc_o = inc_q;
  assign dec_o = dec_q;
  assign err_o = err_q;
endmodule

// File: rtl/quad_edge_decoder.sv
module quad_edge_decoder
  import qed_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_mode,
  input  logic [1:0] edge_sel,
  input  logic       in_a,
  input  logic       in_b,
  output logic       inc_o,
  output logic       dec_o,
  output logic       err_o
);
  logic                 rst_int_n;
  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] filtered;

  assign raw_lines = {in_b, in_a};

  qed_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    qed_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .async_i (raw_lines[g]),
      .sync_o  (synced[g])
    );
    qed_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .smp_i (synced[g]),
      .lvl_o (filtered[g])
    );
  end

  qed_dir_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lvl_i       (filtered),
    .quad_mode_i (quad_mode),
    .edge_sel_i  (edge_sel),
    .inc_o       (inc_o),
    .dec_o       (dec_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/quad_edge_decoder_chk.sv
module quad_edge_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic quad_mode,
  input logic inc_o,
  input logic dec_o,
  input logic err_o
);
  AST_INC_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_o && dec_o)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R9

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !inc_o && !dec_o); // R9

  AST_SINGLE_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_mode && $past(!quad_mode)) |-> !dec_o); // R4

  AST_SINGLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_mode && $past(!quad_mode)) |-> !$rose(err_o)); // R4
endmodule

bind quad_edge_decoder quad_edge_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .quad_mode (quad_mode),
  .inc_o     (inc_o),
  .dec_o     (dec_o),
  .err_o     (err_o)
);

// File: tb/quad_edge_decoder_tb_top.sv
module quad_edge_decoder_tb_top;
  localparam int FILT_LEN = 3;
  localparam int LAT      = FILT_LEN + 3;
  localparam int GAP      = 12;

  logic       clk;
  logic       rst_n;
  logic       quad_mode;
  logic [1:0] edge_sel;
  logic       in_a, in_b;
  logic       inc_o, dec_o, err_o;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_errors = 0;
  bit    run_chk = 0;
  bit    exp_err = 0;
  string cur_tag = "R1";
  int    inc_due[$];
  int    dec_due[$];
  int    err_due[$];
  logic  lvl_a = 0, lvl_b = 0;

  quad_edge_decoder #(.FILT_LEN(FILT_LEN)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .quad_mode (quad_mode),
    .edge_sel  (edge_sel),
    .in_a      (in_a),
    .in_b      (in_b),
    .inc_o     (inc_o),
    .dec_o     (dec_o),
    .err_o     (err_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the expectation queues (R10, R11)
  always @(negedge clk) begin
    if (run_chk) begin
      bit e_inc, e_dec;
      e_inc = 0; e_dec = 0;
      while (inc_due.size() > 0 && inc_due[0] < cyc) void'(inc_due.pop_front());
      while (dec_due.size() > 0 && dec_due[0] < cyc) void'(dec_due.pop_front());
      if (inc_due.size() > 0 && inc_due[0] == cyc) begin e_inc = 1; void'(inc_due.pop_front()); end
      if (dec_due.size() > 0 && dec_due[0] == cyc) begin e_dec = 1; void'(dec_due.pop_front()); end
      while (err_due.size() > 0 && err_due[0] <= cyc) begin exp_err = 1; void'(err_due.pop_front()); end
      check(inc_o === e_inc, cur_tag, "inc_o", int'(inc_o), int'(e_inc));
      check(dec_o === e_dec, cur_tag, "dec_o", int'(dec_o), int'(e_dec));
      check(err_o === exp_err, cur_tag, "err_o", int'(err_o), int'(exp_err));
      check(!(inc_o && dec_o), "R10", "inc_and_dec", 1, 0);
    end
  end

  // Behavioural rule table: 0 none, 1 up, 2 down, 3 illegal
  function automatic int rule(input logic oa, input logic ob,
                              input logic na, input logic nb);
    bit ra, fa, rb, fb, take_r, take_f;
    ra = !oa && na;  fa = oa && !na;
    rb = !ob && nb;  fb = ob && !nb;
    take_r = (edge_sel != 2'd1);
    take_f = (edge_sel != 2'd0);
    if (!quad_mode) return ((ra && take_r) || (fa && take_f)) ? 1 : 0;
    if ((oa != na) && (ob != nb)) return 3;
    if (ra && take_r) return nb ? 2 : 1;
    if (fa && take_f) return nb ? 1 : 2;
    if (rb && take_r) return na ? 1 : 2;
    if (fb && take_f) return na ? 2 : 1;
    return 0;
  endfunction

  task automatic drive(input logic na, input logic nb);
    int k;
    k = rule(lvl_a, lvl_b, na, nb);
    if (k == 1) inc_due.push_back(cyc + LAT);
    if (k == 2) dec_due.push_back(cyc + LAT);
    if (k == 3) err_due.push_back(cyc + LAT);
    in_a = na; in_b = nb;
    lvl_a = na; lvl_b = nb;
  endtask

  task automatic step(input logic na, input logic nb, input string tag);
    @(negedge clk);
    cur_tag = tag;
    drive(na, nb);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic pulse_a(input int width, input string tag);
    @(negedge clk);
    cur_tag = tag;
    if (width >= FILT_LEN) drive(!lvl_a, lvl_b);
    else begin in_a = !lvl_a; end
    repeat (width) @(negedge clk);
    if (width >= FILT_LEN) drive(!lvl_a, lvl_b);
    else begin in_a = lvl_a; end
    repeat (GAP + FILT_LEN) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    run_chk = 0;
    in_a = 0; in_b = 0; lvl_a = 0; lvl_b = 0;
    repeat (GAP) @(negedge clk);
    rst_n = 0;
    inc_due.delete(); dec_due.delete(); err_due.delete();
    exp_err = 0;
    repeat (3) @(negedge clk);
    check(inc_o === 0 && dec_o === 0 && err_o === 0, "R1", "outputs_in_reset",
          int'({inc_o, dec_o, err_o}), 0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    cur_tag = "R1";
    run_chk = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic gray_fwd(input string tag);
    step(1, 0, tag); step(1, 1, tag); step(0, 1, tag); step(0, 0, tag);
  endtask

  task automatic gray_rev(input string tag);
    step(0, 1, tag); step(1, 1, tag); step(1, 0, tag); step(0, 0, tag);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 0; quad_mode = 0; edge_sel = 2'd0; in_a = 0; in_b = 0;
    repeat (3) @(negedge clk);
    do_reset();                                     // R1

    quad_mode = 0; edge_sel = 2'd0;
    step(1, 0, "R2"); step(0, 0, "R2");             // rise counts, fall not
    step(0, 1, "R4"); step(0, 0, "R4");             // B ignored
    edge_sel = 2'd1;
    step(1, 0, "R3"); step(0, 0, "R3");
    edge_sel = 2'd2;
    step(1, 0, "R3"); step(0, 0, "R3");
    edge_sel = 2'd3;
    step(1, 0, "R3"); step(0, 0, "R3");
    step(1, 1, "R4"); step(0, 0, "R4");             // simultaneous, no error

    edge_sel = 2'd0;
    pulse_a(FILT_LEN - 1, "R8");                    // rejected
    pulse_a(FILT_LEN, "R8");                        // accepted
    edge_sel = 2'd2;
    pulse_a(FILT_LEN - 1, "R8");
    pulse_a(FILT_LEN, "R8");

    quad_mode = 1;
    repeat (4) @(negedge clk);
    edge_sel = 2'd0; gray_fwd("R5"); gray_rev("R5");
    edge_sel = 2'd1; gray_fwd("R6"); gray_rev("R6");
    edge_sel = 2'd2; gray_fwd("R7"); gray_rev("R7");
    edge_sel = 2'd3; gray_fwd("R7"); gray_rev("R7");

    step(1, 1, "R9");                               // illegal
    step(1, 0, "R9");                               // still decodes, flag held
    step(0, 1, "R9");                               // illegal again
    step(0, 0, "R9");
    check(err_o === 1, "R9", "err_sticky", int'(err_o), 1);

    quad_mode = 0;
    do_reset();                                     // flag cleared
    check(err_o === 0, "R1", "err_after_reset", int'(err_o), 0);
    step(1, 0, "R2"); step(0, 0, "R2");

    run_chk = 0;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule